// File: doc/BRIEF.md
# Indexed Control Register Window

This block adds an indirect access path to an 8-bit, eight-address serial-port register map. Software first writes an offset into the scratch register at address 7. An access at address 5 then reaches the extended register selected by that offset. A write at address 5 always goes to the selected extended register. A read at address 5 returns the extended register only while the read-enable bit (bit 6) of the extension control register is set. While that bit is clear, address 5 reads whatever the rest of the port supplies on `std_rdata`.

The block holds three writable extended registers and presents their contents on ports:
- the extension control register at offset 0x00;
- the nine-bit framing register at offset 0x0D;
- the clock alteration register at offset 0x13.

It also holds a set of read-only bytes:
- three identification bytes at offsets 0x08, 0x09 and 0x0A, which read 0x16, 0xC9 and 0x50;
- a revision byte at offset 0x0B;
- a port index at offset 0x12, which reads 0.

A one-hot write-hit vector tells the surrounding logic which writable register an access at address 5 has just hit. To return to normal reads, software writes offset 0x00 and then rewrites the extension control register with bit 6 cleared.

Top module: `icr_window`

## Requirements
- R1: After reset the offset and all three writable registers are 0x00, and a read at address 7 returns 0x00.
- R2: A write at address 7 loads the offset, and the new value reads back at address 7 from the next cycle on. Address 7 reads the offset whatever the state of read-enable bit 6.
- R3: A write at address 5 loads the writable register selected by the offset (0x00, 0x0D or 0x13) from the next cycle on, whatever the state of bit 6.
- R4: With bit 6 of the register at offset 0x00 set, a read at address 5 returns the selected register:
  - 0x08 returns 0x16, 0x09 returns 0xC9 and 0x0A returns 0x50;
  - 0x0B returns the revision parameter (default 0x03);
  - 0x12 returns 0x00;
  - a writable offset returns its current value.
- R5: With bit 6 clear, a read at address 5 returns `std_rdata`.
- R6: A read at any address other than 5 or 7 returns `std_rdata`, whatever the state of bit 6.
- R7: A write at address 5 to a read-only or unused offset changes none of the writable registers. A write at an address other than 5 or 7 changes no register of the block.
- R8: With bit 6 set, a read at address 5 of an unused offset returns 0x00.
- R9: `wr_hit` is one-hot in the same cycle as a write at address 5 to a writable offset. Bit 0 stands for offset 0x00, bit 1 for 0x0D and bit 2 for 0x13. It is zero otherwise.
- R10: `rdata` is 0x00 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| std_rdata | input | 8 | Read data from the normal register map |
| rdata | output | 8 | Read data |
| acr_q | output | 8 | Extension control register (offset 0x00) |
| nmr_q | output | 8 | Nine-bit framing register (offset 0x0D) |
| cka_q | output | 8 | Clock alteration register (offset 0x13) |
| wr_hit | output | 3 | One-hot write decode for the writable registers |

## Verification
Reads are combinational: `rdata` is valid in the same cycle as `rd_en`, so the bench drives a read on a falling edge and samples it a moment later. `wr_hit` is also combinational and is sampled in the same window as its write. A write takes effect at the next rising edge, so the register outputs and the read-back are checked on the falling edge after that. Because every result is due either in the same cycle or exactly one edge later, the bench's model updates its state at the same edge as the design.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_WR = 3;

  // writable indexed registers: index 0 = extension control, 1 = nine-bit, 2 = clock alteration
  localparam logic [NUM_WR-1:0][DATA_W-1:0] WR_OFFS = {8'h13, 8'h0D, 8'h00};
  localparam logic [NUM_WR-1:0][DATA_W-1:0] WR_RST  = {8'h00, 8'h00, 8'h00};

  localparam int RD_EN_BIT = 6;

  // read-only indexed contents; unused offsets give zero
  function automatic logic [DATA_W-1:0] ro_value(input logic [DATA_W-1:0] off,
                                                 input logic [DATA_W-1:0] rev);
    case (off)
      8'h08:   ro_value = 8'h16;
      8'h09:   ro_value = 8'hC9;
      8'h0A:   ro_value = 8'h50;
      8'h0B:   ro_value = rev;
      8'h12:   ro_value = 8'h00;
      default: ro_value = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/icr_offset_reg.sv
module icr_offset_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/icr_bank.sv
module icr_bank
  import icr_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr,
  input  logic [DATA_W-1:0]               off,
  input  logic [DATA_W-1:0]               din,
  output logic [NUM_WR-1:0]               hit,
  output logic [NUM_WR-1:0][DATA_W-1:0]   regs_q
);
  for (genvar i = 0; i < NUM_WR; i++) begin : g_reg
    assign hit[i] = wr && (off == WR_OFFS[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[i] <= WR_RST[i];
      else if (hit[i]) regs_q[i] <= din;
    end
  end
endmodule

// File: rtl/icr_rdmux.sv
module icr_rdmux
  import icr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ICR_ADDR = 3'd5,
  parameter logic [ADDR_W-1:0] SPR_ADDR = 3'd7,
  parameter logic [DATA_W-1:0] REV_ID   = 8'h03
) (
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             off,
  input  logic [NUM_WR-1:0][DATA_W-1:0] regs,
  input  logic [DATA_W-1:0]             std_rdata,
  output logic                          win_sel,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] ix_val;

  always_comb begin
    ix_val = ro_value(off, REV_ID);
    for (int i = 0; i < NUM_WR; i++)
      if (off == WR_OFFS[i]) ix_val = regs[i];
  end

  assign win_sel = (addr == ICR_ADDR) && regs[0][RD_EN_BIT];

  always_comb begin
    if (!rd_en)                rdata = '0;
    else if (addr == SPR_ADDR) rdata = off;
    else if (win_sel)          rdata = ix_val;
    else                       rdata = std_rdata;
  end
endmodule

// File: rtl/icr_window.sv
module icr_window
  import icr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ICR_ADDR = 3'd5,
  parameter logic [ADDR_W-1:0] SPR_ADDR = 3'd7,
  parameter logic [DATA_W-1:0] REV_ID   = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  input  logic [7:0]        std_rdata,
  output logic [7:0]        rdata,
  output logic [7:0]        acr_q,
  output logic [7:0]        nmr_q,
  output logic [7:0]        cka_q,
  output logic [2:0]        wr_hit
);
  logic                          off_load;
  logic                          ix_wr;
  logic                          win_sel;
  logic [DATA_W-1:0]             offset_q;
  logic [NUM_WR-1:0][DATA_W-1:0] regs_q;

  assign off_load = wr_en && (addr == SPR_ADDR);
  assign ix_wr    = wr_en && (addr == ICR_ADDR);

  icr_offset_reg #(.W(DATA_W)) u_off (
    .clk(clk), .rst_n(rst_n), .load(off_load), .din(wdata), .q(offset_q)
  );

  icr_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr(ix_wr), .off(offset_q), .din(wdata),
    .hit(wr_hit), .regs_q(regs_q)
  );

  icr_rdmux #(.ICR_ADDR(ICR_ADDR), .SPR_ADDR(SPR_ADDR), .REV_ID(REV_ID)) u_mux (
    .rd_en(rd_en), .addr(addr), .off(offset_q), .regs(regs_q),
    .std_rdata(std_rdata), .win_sel(win_sel), .rdata(rdata)
  );

  assign acr_q = regs_q[0];
  assign nmr_q = regs_q[1];
  assign cka_q = regs_q[2];
endmodule

// File: rtl/icr_window_chk.sv
module icr_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] std_rdata,
  input logic [7:0] rdata,
  input logic [7:0] acr_q,
  input logic [7:0] nmr_q,
  input logic [7:0] cka_q,
  input logic [2:0] wr_hit,
  input logic [7:0] offset_q
);
  AST_OFFSET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7) |=> (offset_q == $past(wdata))); // R2

  AST_ACR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5 && offset_q == 8'h00) |=> (acr_q == $past(wdata))); // R3

  AST_CKA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5 && offset_q == 8'h13) |=> (cka_q == $past(wdata))); // R3

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5 && acr_q[6] && offset_q == 8'h09) |-> (rdata == 8'hC9)); // R4

  AST_NORMAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5 && !acr_q[6]) |-> (rdata == std_rdata)); // R5

  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5 && wr_hit == 3'b000) |=>
      ($stable(acr_q) && $stable(nmr_q) && $stable(cka_q))); // R7

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)); // R9

  AST_HIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit != 3'b000) |-> (wr_en && addr == 3'd5)); // R9

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00)); // R10
endmodule

bind icr_window icr_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .std_rdata(std_rdata), .rdata(rdata), .acr_q(acr_q),
  .nmr_q(nmr_q), .cka_q(cka_q), .wr_hit(wr_hit), .offset_q(offset_q)
);

// File: tb/test_icr_window.sv
module test_icr_window;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] std_rdata = '0;
  logic [7:0] rdata, acr_q, nmr_q, cka_q;
  logic [2:0] wr_hit;

  int total = 0;
  int bad = 0;

  logic [7:0] m_off = 8'h00, m_acr = 8'h00, m_nmr = 8'h00, m_cka = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  icr_window i_icr_window (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .std_rdata(std_rdata), .rdata(rdata), .acr_q(acr_q),
    .nmr_q(nmr_q), .cka_q(cka_q), .wr_hit(wr_hit)
  );

  function automatic logic [2:0] exp_hit(input logic [7:0] off);
    if (off == 8'h00) return 3'b001;
    if (off == 8'h0D) return 3'b010;
    if (off == 8'h13) return 3'b100;
    return 3'b000;
  endfunction

  function automatic logic [7:0] exp_window(input logic [7:0] off);
    case (off)
      8'h00: return m_acr;
      8'h0D: return m_nmr;
      8'h13: return m_cka;
      8'h08: return 8'h16;
      8'h09: return 8'hC9;
      8'h0A: return 8'h50;
      8'h0B: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [7:0] s);
    if (a == 3'd7) return m_off;
    if (a == 3'd5 && m_acr[6]) return exp_window(m_off);
    return s;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1;
    check("R9", {5'b0, wr_hit}, {5'b0, (a == 3'd5) ? exp_hit(m_off) : 3'b000});
    @(posedge clk);
    if (a == 3'd7) m_off = d;
    else if (a == 3'd5) begin
      case (m_off)
        8'h00: m_acr = d;
        8'h0D: m_nmr = d;
        8'h13: m_cka = d;
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [2:0] a, input logic [7:0] s);
    @(negedge clk);
    addr = a; std_rdata = s; rd_en = 1'b1;
    #1;
    check(req, rdata, exp_read(a, s));
    rd_en = 1'b0;
    #1;
    check("R10", rdata, 8'h00);
  endtask

  task automatic check_regs(input string req);
    check(req, acr_q, m_acr);
    check(req, nmr_q, m_nmr);
    check(req, cka_q, m_cka);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] offs [8] = '{8'h00, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0D, 8'h12, 8'h13};
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check_regs("R1");
    do_read("R1", 3'd7, 8'hAA);
    do_read("R5", 3'd5, 8'h5C);

    // R2: offset load and read back
    do_write(3'd7, 8'h0D);
    do_read("R2", 3'd7, 8'h11);

    // R3: writes with read enable clear
    do_write(3'd5, 8'h01);
    check_regs("R3");
    do_write(3'd7, 8'h13);
    do_write(3'd5, 8'hE7);
    check_regs("R3");

    // open the window
    do_write(3'd7, 8'h00);
    do_write(3'd5, 8'h40);
    check_regs("R3");

    // R4: ID and fixed bytes
    for (int k = 0; k < 8; k++) begin
      do_write(3'd7, offs[k]);
      do_read("R4", 3'd5, 8'h77);
    end

    // R8: unused offsets read zero
    do_write(3'd7, 8'h05);
    do_read("R8", 3'd5, 8'hFF);
    do_write(3'd7, 8'hFE);
    do_read("R8", 3'd5, 8'hFF);

    // R7: writes to read-only or unused offsets
    do_write(3'd7, 8'h09);
    do_write(3'd5, 8'h33);
    check_regs("R7");
    do_read("R4", 3'd5, 8'h00);
    do_write(3'd7, 8'h12);
    do_write(3'd5, 8'h99);
    check_regs("R7");

    // R6: other addresses pass through while the window is open
    do_read("R6", 3'd0, 8'h3C);
    do_read("R6", 3'd3, 8'hC3);

    // R7: a write at an address other than 5 or 7 touches no register of the block
    do_write(3'd2, 8'h5A);
    check_regs("R7");
    do_read("R7", 3'd7, 8'h00);

    // R2: address 7 reads the offset while the window is open
    do_write(3'd7, 8'h2B);
    do_read("R2", 3'd7, 8'h00);

    // close the window
    do_write(3'd7, 8'h00);
    do_write(3'd5, m_acr & 8'hBF);
    do_read("R5", 3'd5, 8'h6D);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: begin
          logic [7:0] o;
          o = ($urandom_range(0, 3) == 0) ? 8'($urandom) : offs[$urandom_range(0, 7)];
          do_write(3'd7, o);
        end
        1: begin
          do_write(3'd5, 8'($urandom));
          check_regs("R3");
        end
        2: do_read((m_acr[6] ? "R4" : "R5"), 3'd5, 8'($urandom));
        default: begin
          logic [2:0] a;
          a = 3'($urandom);
          do_read((a == 3'd7) ? "R2" : ((a == 3'd5) ? (m_acr[6] ? "R4" : "R5") : "R6"),
                  a, 8'($urandom));
        end
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule